// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns a 24-bit bus address into four active-low chip-select lines, one for each programmable address window. Each window has a base register that holds the upper eight address bits, a mask register that lists the address bits to leave out of the comparison, and a control register with an enable bit. Software programs the windows through a small write-only register port. The host bus marks each bus cycle with a valid strobe. In every such cycle the block compares the address against all enabled windows and drives the chip select of the winning window low on the next clock.

Each window has its own range of address bits that can be masked. Address bits above that range are always compared. Address bits below that range are never compared. After reset only window 2 is enabled. Its mode bit starts cleared, and in that state window 2 answers to the whole 16 MB address space. Setting the mode bit makes window 2 decode from its base and mask registers like the other windows. When windows overlap, the lowest-numbered hit wins.

Top module: `csw_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cs_n` is all ones. After reset, window 2 is enabled with its mode bit cleared. Windows 0, 1 and 3 are disabled. Every base and mask register holds zero.
- R2: `cs_n` is registered. It reflects the bus cycle sampled on the previous rising edge. It is all ones after any edge at which `bus_valid` was low.
- R3: A base register holds address bits A23..A16, and its value is written from `cfg_wdata[7:0]`. An enabled, programmed window hits when every compared address bit equals the base address, taking base bits A15..A0 as zero.
- R4: Mask bit k (`cfg_wdata[k]`, k = 0..15) stands for address bit A(k+8). A 1 removes that bit from the comparison and a 0 keeps it. Window 0 can mask A20..A8, always compares A23..A21 and never compares A7..A0.
- R5: Window 1 can mask A21..A8, always compares A23..A22 and never compares A7..A0.
- R6: Windows 2 and 3 can mask A22..A15, always compare A23 and never compare A14..A0. Written mask bits outside a window's range have no effect.
- R7: While window 2 is enabled and its mode bit is 0, it hits on every address. With the mode bit at 1 it uses its base and mask registers.
- R8: A window whose enable bit is 0 never drives its chip select low.
- R9: When several windows hit, only the lowest-numbered one drives its chip select low. At most one `cs_n` bit is ever low.
- R10: A register write in a given cycle does not affect a decode sampled on the same edge. It takes effect from the next bus cycle onward.
- R11: `cfg_sel` chooses the register: 0 for base, 1 for mask, 2 for control (bit 0 = enable, bit 1 = mode). The value 3 writes nothing. The mode bit is held only by window 2; on other windows it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is active this clock |
| bus_addr | input | 24 | Bus address A23..A0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_area | input | 2 | Window index of the write |
| cfg_sel | input | 2 | Register select: 0 base, 1 mask, 2 control, 3 none |
| cfg_wdata | input | 16 | Write data |
| cs_n | output | 4 | Active-low chip selects, one per window |

## Verification
The hardest cases to reach from the ports are the exact edges of each window's maskable range combined with overlaps between windows. Purely random addresses almost never land inside a small programmed window. The bench therefore draws many addresses from a randomly chosen window's own base, flips only bits in a random subset of the positions, and mixes in single-bit flips just outside the range. Directed sequences first turn window 2 off its full-range mode and then stack windows 0 and 2 on the same addresses, so that priority, the fixed compare bits and the write-then-decode timing all show up at the chip-select pins.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int ADDR_W    = 24;
    localparam int START_W   = 8;
    localparam int START_LSB = ADDR_W - START_W;
    localparam int MASK_LSB  = 8;
    localparam int MASK_W    = ADDR_W - MASK_LSB;
    localparam int CFG_W     = 16;
    localparam int FULL_AREA = 2;

    localparam int LO_FINE   = 8;
    localparam int LO_COARSE = 15;
    localparam int HI_AREA0  = 20;
    localparam int HI_AREA1  = 21;
    localparam int HI_WIDE   = 22;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [START_W-1:0] base;
        logic [MASK_W-1:0]  mask;
        logic               en;
        logic               prog;
    } area_cfg_t;

    function automatic int mask_lo(int area);
        return (area < 2) ? LO_FINE : LO_COARSE;
    endfunction

    function automatic int mask_hi(int area);
        case (area)
            0:       return HI_AREA0;
            1:       return HI_AREA1;
            default: return HI_WIDE;
        endcase
    endfunction

    function automatic logic [MASK_W-1:0] maskable_bits(int area);
        logic [MASK_W-1:0] m;
        m = '0;
        for (int b = 0; b < MASK_W; b++) begin
            if ((b + MASK_LSB) >= mask_lo(area) && (b + MASK_LSB) <= mask_hi(area))
                m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] care_floor(int area);
        logic [ADDR_W-1:0] f;
        f = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (b >= mask_lo(area))
                f[b] = 1'b1;
        end
        return f;
    endfunction

endpackage

// File: rtl/csw_area_regs.sv
module csw_area_regs
    import csw_pkg::*;
#(
    parameter int AREA_IDX = 0,
    parameter int AREA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [AREA_W-1:0] cfg_area,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output area_cfg_t         cfg
);

    localparam logic [MASK_W-1:0] MASKABLE = maskable_bits(AREA_IDX);
    localparam bit                HAS_MODE = (AREA_IDX == FULL_AREA);
    localparam logic              EN_RST   = HAS_MODE ? 1'b1 : 1'b0;

    logic     hit_me;
    cfg_sel_e sel;

    assign hit_me = cfg_we && (cfg_area == AREA_W'(AREA_IDX));
    assign sel    = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.base <= '0;
            cfg.mask <= '0;
            cfg.en   <= EN_RST;
            cfg.prog <= 1'b0;
        end else if (hit_me) begin
            case (sel)
                SEL_BASE: cfg.base <= cfg_wdata[START_W-1:0];
                SEL_MASK: cfg.mask <= cfg_wdata[MASK_W-1:0] & MASKABLE;
                SEL_CTRL: begin
                    cfg.en   <= cfg_wdata[0];
                    cfg.prog <= HAS_MODE ? cfg_wdata[1] : 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/csw_area_match.sv
module csw_area_match
    import csw_pkg::*;
#(
    parameter int AREA_IDX = 0
) (
    input  area_cfg_t         cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] FLOOR    = care_floor(AREA_IDX);
    localparam bit                HAS_MODE = (AREA_IDX == FULL_AREA);

    logic [ADDR_W-1:0] care;
    logic [ADDR_W-1:0] diff;
    logic              window_ok;

    always_comb begin
        care      = FLOOR & ~{cfg.mask, {MASK_LSB{1'b0}}};
        diff      = addr ^ {cfg.base, {START_LSB{1'b0}}};
        window_ok = ((diff & care) == '0);
        if (HAS_MODE && !cfg.prog)
            hit = cfg.en;
        else
            hit = cfg.en && window_ok;
    end

endmodule

// File: rtl/csw_lowest_grant.sv
module csw_lowest_grant #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    always_comb begin
        grant = req & (~req + N'(1));
    end

endmodule

// File: rtl/csw_decoder.sv
module csw_decoder
    import csw_pkg::*;
#(
    parameter int N_AREAS = 4,
    parameter int AREA_W  = (N_AREAS > 1) ? $clog2(N_AREAS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                cfg_we,
    input  logic [AREA_W-1:0]   cfg_area,
    input  logic [1:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [N_AREAS-1:0]  cs_n
);

    area_cfg_t          area_cfg [N_AREAS];
    logic [N_AREAS-1:0] area_hit;
    logic [N_AREAS-1:0] area_en;
    logic [N_AREAS-1:0] area_grant;

    for (genvar i = 0; i < N_AREAS; i++) begin : g_area
        csw_area_regs #(
            .AREA_IDX (i),
            .AREA_W   (AREA_W)
        ) u_regs (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we),
            .cfg_area  (cfg_area),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .cfg       (area_cfg[i])
        );

        csw_area_match #(
            .AREA_IDX (i)
        ) u_match (
            .cfg  (area_cfg[i]),
            .addr (bus_addr),
            .hit  (area_hit[i])
        );

        assign area_en[i] = area_cfg[i].en;
    end

    csw_lowest_grant #(
        .N (N_AREAS)
    ) u_grant (
        .req   (area_hit),
        .grant (area_grant)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cs_n <= '1;
        else if (bus_valid)
            cs_n <= ~area_grant;
        else
            cs_n <= '1;
    end

endmodule

// File: rtl/csw_decoder_chk.sv
module csw_decoder_chk #(
    parameter int N_AREAS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_valid,
    input logic [N_AREAS-1:0] area_hit,
    input logic [N_AREAS-1:0] area_en,
    input logic [N_AREAS-1:0] cs_n
);

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> (cs_n == '1));

    // R9
    single_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R9
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && area_hit[0]) |=> (cs_n[0] == 1'b0));

    // R3
    hit_selects_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && (area_hit != '0)) |=> ($countones(~cs_n) == 1));

    // R8
    miss_release_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && (area_hit == '0)) |=> (cs_n == '1));

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (area_hit & ~area_en) == '0);

endmodule

bind csw_decoder csw_decoder_chk #(.N_AREAS(N_AREAS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .area_hit  (area_hit),
    .area_en   (area_en),
    .cs_n      (cs_n)
);

// File: tb/csw_decoder_tb.sv
module csw_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_area = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  cs_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0]  m_base [4];
    logic [15:0] m_mask [4];
    bit          m_en   [4];
    bit          m_prog;

    always #4 clk = ~clk;

    csw_decoder u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .cfg_we    (cfg_we),
        .cfg_area  (cfg_area),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cs_n      (cs_n)
    );

    function automatic int lo_of(int a);
        return (a < 2) ? 8 : 15;
    endfunction

    function automatic int hi_of(int a);
        return (a == 0) ? 20 : (a == 1) ? 21 : 22;
    endfunction

    function automatic logic [15:0] range_bits(int a);
        logic [15:0] m = '0;
        for (int b = 8; b < 24; b++)
            if (b >= lo_of(a) && b <= hi_of(a)) m[b-8] = 1'b1;
        return m;
    endfunction

    function automatic bit model_hit(int a, logic [23:0] addr);
        logic [23:0] basea;
        if (!m_en[a]) return 1'b0;
        if (a == 2 && !m_prog) return 1'b1;
        basea = {m_base[a], 16'h0000};
        for (int b = lo_of(a); b < 24; b++) begin
            if (b <= 23 && m_mask[a][b-8]) continue;
            if (addr[b] != basea[b]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [3:0] model_cs(bit valid, logic [23:0] addr);
        if (!valid) return 4'hF;
        for (int a = 0; a < 4; a++)
            if (model_hit(a, addr)) return ~(4'b0001 << a);
        return 4'hF;
    endfunction

    task automatic model_write(logic [1:0] a, logic [1:0] s, logic [15:0] d);
        case (s)
            2'd0: m_base[a] = d[7:0];
            2'd1: m_mask[a] = d & range_bits(a);
            2'd2: begin
                m_en[a] = d[0];
                if (a == 2) m_prog = d[1];
            end
            default: ;
        endcase
    endtask

    task automatic check(string req, logic [3:0] exp);
        checks++;
        if (cs_n !== exp) begin
            fails++;
            $display("FAIL %s cs_n=%b expected=%b", req, cs_n, exp);
        end
    endtask

    // one clock: drive at negedge, sample at the following negedge
    task automatic step(bit we, logic [1:0] a, logic [1:0] s, logic [15:0] d,
                        bit valid, logic [23:0] addr, bit chk, string req);
        logic [3:0] exp;
        cfg_we = we; cfg_area = a; cfg_sel = s; cfg_wdata = d;
        bus_valid = valid; bus_addr = addr;
        exp = model_cs(valid, addr);
        @(posedge clk);
        if (we) model_write(a, s, d);
        @(negedge clk);
        cfg_we = 1'b0; bus_valid = 1'b0;
        if (chk) check(req, exp);
    endtask

    task automatic wr(logic [1:0] a, logic [1:0] s, logic [15:0] d);
        step(1'b1, a, s, d, 1'b0, 24'h0, 1'b0, "");
    endtask

    task automatic rd(logic [23:0] addr, string req);
        step(1'b0, 2'd0, 2'd0, 16'h0, 1'b1, addr, 1'b1, req);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired cycles=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_C5D1);
        for (int a = 0; a < 4; a++) begin
            m_base[a] = '0; m_mask[a] = '0; m_en[a] = (a == 2);
        end
        m_prog = 1'b0;

        repeat (3) @(negedge clk);
        bus_valid = 1'b1; bus_addr = 24'h123456;
        @(negedge clk);
        check("R1", 4'hF);                       // reset holds cs_n high
        rst = 1'b0; bus_valid = 1'b0;
        @(negedge clk);
        check("R1", 4'hF);                       // first cycle after reset

        rd(24'hFFFFFF, "R1");                    // window 2 full range after reset
        rd(24'h000000, "R7");
        rd(24'h9ABCDE, "R7");
        step(1'b0, 0, 0, 0, 1'b0, 24'h000000, 1'b1, "R2");  // idle releases
        wr(2, 2'd3, 16'hFFFF);                   // R11 select 3 writes nothing
        rd(24'h800000, "R11");

        wr(2, 2'd0, 16'h0040);
        step(1'b1, 2, 2'd2, 16'h0003, 1'b1, 24'h000000, 1'b1, "R10");
        rd(24'h000000, "R7");                    // now programmed: miss
        rd(24'h407FFF, "R6");                    // A14..A0 ignored
        rd(24'h408000, "R6");                    // A15 compared when unmasked
        wr(2, 2'd1, 16'hFFFF);
        rd(24'h7F8123, "R6");                    // A22..A15 masked
        rd(24'h800000, "R6");                    // A23 always compared

        wr(0, 2'd0, 16'h0012);
        wr(0, 2'd1, 16'h00FF);
        wr(0, 2'd2, 16'h0001);
        rd(24'h12AB34, "R9");                    // window 0 beats window 2
        rd(24'h13AB34, "R4");
        wr(0, 2'd1, 16'hFFFF);
        rd(24'h0F0000, "R4");
        rd(24'h200000, "R4");

        wr(0, 2'd2, 16'h0000);
        wr(2, 2'd2, 16'h0002);
        rd(24'h12AB34, "R8");
        wr(1, 2'd0, 16'h0020);
        wr(1, 2'd1, 16'hFFFF);
        wr(1, 2'd2, 16'h0003);
        rd(24'h3FFFFF, "R5");
        rd(24'h400000, "R5");
        rd(24'h1FFFFF, "R5");
        wr(1, 2'd2, 16'h0000);
        rd(24'h200000, "R8");

        wr(3, 2'd2, 16'h0003);                   // mode bit ignored on window 3
        rd(24'h000000, "R11");
        rd(24'h7FFFFF, "R3");
        rd(24'h800000, "R3");

        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  a, s;
            logic [15:0] d;
            logic [23:0] addr;
            bit          we;
            int          pick;
            we = ($urandom % 4) == 0;
            a  = 2'($urandom);
            s  = 2'($urandom);
            d  = 16'($urandom);
            if (s == 2'd2 && ($urandom % 4) != 0) d[0] = 1'b1;
            pick = $urandom % 4;
            addr = {m_base[pick], 16'h0} ^ (24'($urandom) & {m_mask[pick], 8'hFF});
            if (($urandom % 5) == 0) addr = addr ^ (24'h1 << ($urandom % 24));
            if (($urandom % 8) == 0) addr = 24'($urandom);
            step(we, a, s, d, ($urandom % 8) != 0, addr, 1'b1, "R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule